// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port (Master/Slave)

This block is a synchronous serial port that moves one byte at a time over a four-wire link made of clock, two data lines and an active-low select. A host processor reaches it through a small register port. One address holds the configuration. One address holds four sticky status flags. One address is shared by both directions: a write loads the transmit shifter, and a read returns the most recently received byte.

As a master, the block generates the serial clock from the bus clock through a selectable divider. It drives its own select output low for the length of a byte. As a slave, it resynchronises the incoming clock, select and data into the bus clock domain and follows edges of the external clock. Clock polarity, clock phase and bit order are all programmable.

Transmit is single-buffered, and a write during a transfer is refused and flagged. Receive is double-buffered through a read buffer, and a byte that completes while the previous one is unread is flagged as an overrun. A master whose select input is pulled active by another device records a mode fault and falls back to an inactive slave.

Top module: `spi_port`

## Requirements
- R1: After reset the configuration and status registers read 0, `ssOutN` is 1, `sckOut` is 0, and `masterOe` and `slaveOe` are 0.
- R2: Address 0 is configuration, bits [6:0] = {divSel[1:0], lsbFirst, cpha, cpol, master, enable}, and reads back what was written. Address 1 is status, bits [3:0] = {modeFault, overrun, writeCollision, done}. Address 2 is the data register. Address 3 reads 0.
- R3: An enabled idle master starts a transfer on a data write. `ssOutN` is low for exactly 16·H bus cycles, where H = 1, 2, 8, 16 for divSel 0, 1, 2, 3, so one serial clock period is 2·H bus cycles. `sckOut` rests at cpol.
- R4: With cpha=0, bits are sampled on leading clock edges (edges away from cpol); with cpha=1, bits are sampled on trailing edges. Bits go out MSB first, or LSB first when lsbFirst=1. The received byte is assembled in the same order.
- R5: At the end of a byte the done flag sets and the received byte is copied into the read buffer.
- R6: A data write while a transfer is in progress sets writeCollision. The shifter is untouched, so the byte in flight still goes out.
- R7: If a byte completes while done is still set, overrun sets and the read buffer keeps the earlier byte.
- R8: A status read followed by a data access (read or write) clears the flags that were set in that status read. A flag that sets in the same cycle as the clearing access stays set.
- R9: If the block is an enabled master and `ssInN` is low, modeFault sets, the enable and master bits clear, and `masterOe` falls.
- R10: As an enabled slave with `ssInN` low, the block receives a byte on `mosiIn` and sends its preloaded byte on `misoOut`. The same phase and order rules as R4 apply, for `sckIn` levels held at least 2 bus cycles. `slaveOe` is 1 only while the block is an enabled slave and `ssInN` is low.
- R11: In slave mode a data write while `ssInN` is low sets writeCollision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (used for flag clearing) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational on regAddr |
| sckIn | input | 1 | Serial clock from an external master |
| ssInN | input | 1 | Select input, active low |
| mosiIn | input | 1 | Serial data in, slave mode |
| misoIn | input | 1 | Serial data in, master mode |
| sckOut | output | 1 | Serial clock generated as master |
| ssOutN | output | 1 | Select output, low during a master transfer |
| mosiOut | output | 1 | Serial data out, master mode |
| misoOut | output | 1 | Serial data out, slave mode |
| masterOe | output | 1 | Drive enable for sckOut, mosiOut, ssOutN |
| slaveOe | output | 1 | Drive enable for misoOut |

## Verification
The sharp case is a byte that completes in the very cycle the host makes the data access meant to clear done. In that cycle the new completion and the clearing access compete for the same flag.

The bench sets this up with a master transfer at a known divider. It starts the second byte while done is still set, arms the flags with a status read, and places the data read exactly 16·H cycles after the starting write. It then expects done to survive, overrun to be set, and the read buffer to still hold the first byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // copy write data into tx shifter
    logic shift;    // advance tx shifter
    logic sample;   // take rxBit into rx shifter
    logic capture;  // copy received byte into read buffer
    logic rxBit;    // selected serial input
  } dpStb_t;
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] wdata,
  output logic              txBit,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] txSh, rxSh, rxNext, rxByte;

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) flip[i] = v[DATA_W-1-i];
  endfunction

  assign rxNext = {rxSh[DATA_W-2:0], stb.rxBit};
  assign rxByte = stb.sample ? rxNext : rxSh;
  assign txBit  = txSh[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      rxSh  <= '0;
      rxBuf <= '0;
    end else begin
      if (stb.load)       txSh <= lsbFirst ? flip(wdata) : wdata;
      else if (stb.shift) txSh <= {txSh[DATA_W-2:0], 1'b0};
      if (stb.sample)     rxSh <= rxNext;
      if (stb.capture)    rxBuf <= lsbFirst ? flip(rxByte) : rxByte;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [6:0] cfgWdata,
  input  logic       sckIn,
  input  logic       ssInN,
  input  logic       mosiIn,
  input  logic       misoIn,
  output logic [7:0] cfgVal,
  output logic [3:0] statVal,
  output logic       lsbFirst,
  output dpStb_t     stb,
  output logic       sckOut,
  output logic       ssOutN,
  output logic       masterOe,
  output logic       slaveOe
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int DIV_W  = 4;

  logic spiEn, isMaster, cpol, cpha;
  logic [1:0] divSel;
  logic flagDone, flagWcol, flagOvr, flagModf;
  logic [3:0] armMask;
  logic [SYNC_STAGES-1:0] sckSh, ssSh, mosiSh;
  logic sckPrev, mActive, sckLvl;
  logic [DIV_W-1:0] divCnt, halfLast;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0] sBits;

  logic cfgWr, statRd, dataWr, dataAcc;
  logic sckS, ssS, mosiS, busyNow, modfTrig, mTick, lastEdge, edgeOdd;
  logic slaveOn, leadEv, trailEv, mSample, mShift, sSample, sShift, doneStb, startM;

  assign cfgWr   = regWr && regAddr == ADDR_CFG;
  assign statRd  = regRd && regAddr == ADDR_STAT;
  assign dataWr  = regWr && regAddr == ADDR_DATA;
  assign dataAcc = (regWr || regRd) && regAddr == ADDR_DATA;

  assign sckS  = sckSh[SYNC_STAGES-1];
  assign ssS   = ssSh[SYNC_STAGES-1];
  assign mosiS = mosiSh[SYNC_STAGES-1];

  always_comb begin
    case (divSel)
      2'd0:    halfLast = DIV_W'(0);
      2'd1:    halfLast = DIV_W'(1);
      2'd2:    halfLast = DIV_W'(7);
      default: halfLast = DIV_W'(15);
    endcase
  end

  assign busyNow  = isMaster ? mActive : (spiEn && !ssS);
  assign modfTrig = spiEn && isMaster && !ssS;
  assign mTick    = mActive && divCnt == halfLast;
  assign edgeOdd  = edgeCnt[0];
  assign lastEdge = edgeCnt == EDGE_W'(EDGES - 1);
  assign mSample  = mTick && (edgeOdd == cpha);
  assign mShift   = mTick && (cpha ? (!edgeOdd && edgeCnt != '0) : edgeOdd);

  assign slaveOn  = spiEn && !isMaster && !ssS;
  assign leadEv   = slaveOn && (sckS != cpol) && (sckPrev == cpol);
  assign trailEv  = slaveOn && (sckS == cpol) && (sckPrev != cpol);
  assign sSample  = cpha ? trailEv : leadEv;
  assign sShift   = cpha ? (leadEv && sBits != '0) : trailEv;

  assign doneStb  = isMaster ? (mTick && lastEdge)
                             : (sSample && sBits == CNT_W'(DATA_W - 1));

  assign stb.load    = dataWr && !busyNow;
  assign stb.shift   = isMaster ? mShift : sShift;
  assign stb.sample  = isMaster ? mSample : sSample;
  assign stb.capture = doneStb && !flagDone;
  assign stb.rxBit   = isMaster ? misoIn : mosiS;
  assign startM      = stb.load && spiEn && isMaster && !modfTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {divSel, lsbFirst, cpha, cpol, isMaster, spiEn} <= '0;
      sckSh   <= '0;
      ssSh    <= '1;
      mosiSh  <= '0;
      sckPrev <= 1'b0;
      mActive <= 1'b0;
      sckLvl  <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sBits   <= '0;
      {flagModf, flagOvr, flagWcol, flagDone} <= '0;
      armMask <= '0;
    end else begin
      sckSh   <= {sckSh[SYNC_STAGES-2:0], sckIn};
      ssSh    <= {ssSh[SYNC_STAGES-2:0], ssInN};
      mosiSh  <= {mosiSh[SYNC_STAGES-2:0], mosiIn};
      sckPrev <= sckS;

      if (cfgWr) {divSel, lsbFirst, cpha, cpol, isMaster, spiEn} <= cfgWdata;
      if (modfTrig) begin
        spiEn    <= 1'b0;
        isMaster <= 1'b0;
      end

      if (startM) begin
        mActive <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
        sckLvl  <= 1'b0;
      end else if (mActive) begin
        if (!(spiEn && isMaster) || modfTrig) begin
          mActive <= 1'b0;
          sckLvl  <= 1'b0;
        end else if (mTick) begin
          divCnt  <= '0;
          sckLvl  <= !sckLvl;
          edgeCnt <= edgeCnt + 1'b1;
          if (lastEdge) mActive <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      if (!slaveOn) sBits <= '0;
      else if (sSample) sBits <= (sBits == CNT_W'(DATA_W - 1)) ? '0 : sBits + 1'b1;

      flagDone <= doneStb || (flagDone && !(dataAcc && armMask[0]));
      flagWcol <= (dataWr && busyNow) || (flagWcol && !(dataAcc && armMask[1]));
      flagOvr  <= (doneStb && flagDone) || (flagOvr && !(dataAcc && armMask[2]));
      flagModf <= modfTrig || (flagModf && !(dataAcc && armMask[3]));

      if (statRd) armMask <= statVal;
      else if (dataAcc) armMask <= '0;
    end
  end

  assign cfgVal   = {1'b0, divSel, lsbFirst, cpha, cpol, isMaster, spiEn};
  assign statVal  = {flagModf, flagOvr, flagWcol, flagDone};
  assign sckOut   = cpol ^ sckLvl;
  assign ssOutN   = !mActive;
  assign masterOe = spiEn && isMaster;
  assign slaveOe  = spiEn && !isMaster && !ssInN;

  // R6 and R11: a data write during a transfer always leaves the collision flag set
  p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busyNow) |=> flagWcol);
  // R7: completing a byte on an unread buffer records overrun
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && flagDone) |=> flagOvr);
  // R9: a contested select demotes the master
  p_modf_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    modfTrig |=> (flagModf && !isMaster && !spiEn));
  // R3: the sixteenth clock edge ends the master transfer and raises done
  p_byte_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mTick && lastEdge && spiEn && isMaster && !modfTrig) |=> (!mActive && flagDone));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sckIn,
  input  logic              ssInN,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              sckOut,
  output logic              ssOutN,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              masterOe,
  output logic              slaveOe
);
  dpStb_t stb;
  logic [7:0] cfgVal;
  logic [3:0] statVal;
  logic lsbFirst, txBit;
  logic [DATA_W-1:0] rxBuf;

  spi_port_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .cfgWdata(regWdata[6:0]), .sckIn(sckIn), .ssInN(ssInN), .mosiIn(mosiIn),
    .misoIn(misoIn), .cfgVal(cfgVal), .statVal(statVal), .lsbFirst(lsbFirst),
    .stb(stb), .sckOut(sckOut), .ssOutN(ssOutN), .masterOe(masterOe),
    .slaveOe(slaveOe)
  );

  spi_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lsbFirst(lsbFirst),
    .wdata(regWdata), .txBit(txBit), .rxBuf(rxBuf)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdata = DATA_W'(cfgVal);
      ADDR_STAT: regRdata = DATA_W'(statVal);
      ADDR_DATA: regRdata = rxBuf;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic sckIn = 1'b0, ssInN = 1'b1, mosiIn = 1'b0, misoIn;
  logic sckOut, ssOutN, mosiOut, misoOut, masterOe, slaveOe;
  logic invMiso = 1'b0;
  logic curCpha = 1'b0;

  int nChecks = 0, nFails = 0, cycles = 0;
  int lowCnt = 0, monCnt = 0;
  logic [7:0] monByte = '0;
  logic sckPrevTb = 1'b0;

  always #2 clk = !clk;

  assign misoIn = mosiOut ^ invMiso;

  spi_port uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sckIn(sckIn), .ssInN(ssInN),
    .mosiIn(mosiIn), .misoIn(misoIn), .sckOut(sckOut), .ssOutN(ssOutN),
    .mosiOut(mosiOut), .misoOut(misoOut), .masterOe(masterOe), .slaveOe(slaveOe)
  );

  // bus-side observer of the master link
  always @(negedge clk) begin
    if (!ssOutN) lowCnt = lowCnt + 1;
    if (sckOut != sckPrevTb) begin
      if (monCnt[0] == curCpha) monByte = {monByte[6:0], mosiOut};
      monCnt = monCnt + 1;
    end
    sckPrevTb = sckOut;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog (R1..) act=%0d exp<150000", cycles);
      summary();
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic int halfOf(input logic [1:0] d);
    case (d)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] cfgWord(input logic [1:0] d, input logic lsb,
                                          input logic ph, input logic pol,
                                          input logic mst);
    return {1'b0, d, lsb, ph, pol, mst, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (!ssOutN && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic clearFlags();
    logic [7:0] v;
    rdReg(2'd1, v);
    rdReg(2'd2, v);
  endtask

  task automatic masterXfer(input logic [1:0] d, input logic lsb, input logic ph,
                            input logic pol, input logic [7:0] data, input logic inv);
    logic [7:0] v;
    wrReg(2'd0, cfgWord(d, lsb, ph, pol, 1'b1));
    @(negedge clk);
    curCpha = ph; invMiso = inv;
    monCnt = 0; monByte = '0; lowCnt = 0;
    wrReg(2'd2, data);
    waitIdle();
    chk(lowCnt == 16 * halfOf(d), "R3 select low length", lowCnt, 16 * halfOf(d));
    chk(sckOut == pol, "R3 clock rest level", sckOut, pol);
    chk(monByte == (lsb ? rev8(data) : data), "R4 bit order on mosi", monByte,
        lsb ? rev8(data) : data);
    rdReg(2'd1, v);
    chk(v == 8'h01, "R5 done after byte", v, 8'h01);
    rdReg(2'd2, v);
    chk(v == (data ^ {8{inv}}), "R5 R4 received byte", v, data ^ {8{inv}});
    rdReg(2'd1, v);
    chk(v == 8'h00, "R8 flags cleared", v, 8'h00);
  endtask

  task automatic slaveXfer(input logic lsb, input logic ph, input logic pol,
                           input logic [7:0] txd, input logic [7:0] md);
    logic [7:0] got = '0;
    logic [7:0] v;
    logic b;
    sckIn = pol;
    wrReg(2'd0, cfgWord(2'd0, lsb, ph, pol, 1'b0));
    wrReg(2'd2, txd);
    repeat (4) @(negedge clk);
    ssInN = 1'b0;
    repeat (4) @(negedge clk);
    chk(slaveOe == 1'b1, "R10 slave drive while selected", slaveOe, 1);
    for (int i = 0; i < 8; i++) begin
      b = lsb ? md[i] : md[7-i];
      if (!ph) begin
        mosiIn = b;
        repeat (4) @(negedge clk);
        got = {got[6:0], misoOut};
        sckIn = !pol;
        repeat (4) @(negedge clk);
        sckIn = pol;
        repeat (4) @(negedge clk);
      end else begin
        sckIn = !pol; mosiIn = b;
        repeat (4) @(negedge clk);
        got = {got[6:0], misoOut};
        sckIn = pol;
        repeat (4) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    ssInN = 1'b1;
    repeat (4) @(negedge clk);
    chk(slaveOe == 1'b0, "R10 slave released", slaveOe, 0);
    chk(got == (lsb ? rev8(txd) : txd), "R10 slave sends preload", got,
        lsb ? rev8(txd) : txd);
    rdReg(2'd1, v);
    chk(v == 8'h01, "R10 slave done", v, 8'h01);
    rdReg(2'd2, v);
    chk(v == md, "R10 slave received byte", v, md);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, v); chk(v == 8'h00, "R1 config at reset", v, 0);
    rdReg(2'd1, v); chk(v == 8'h00, "R1 status at reset", v, 0);
    chk(ssOutN == 1'b1, "R1 select idle", ssOutN, 1);
    chk(sckOut == 1'b0, "R1 clock idle", sckOut, 0);
    chk(masterOe == 1'b0 && slaveOe == 1'b0, "R1 drivers off", {masterOe, slaveOe}, 0);

    // R2 register map
    wrReg(2'd0, 8'h5d);
    rdReg(2'd0, v); chk(v == 8'h5d, "R2 config read back", v, 8'h5d);
    rdReg(2'd3, v); chk(v == 8'h00, "R2 unused address", v, 0);
    wrReg(2'd0, 8'h00);

    // directed master cases over every divider
    for (int d = 0; d < 4; d++) masterXfer(2'(d), 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0);
    masterXfer(2'd1, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1);

    // R6 write collision in master mode
    wrReg(2'd0, cfgWord(2'd1, 1'b0, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    curCpha = 1'b0; invMiso = 1'b0; monCnt = 0; monByte = '0;
    wrReg(2'd2, 8'h3C);
    repeat (5) @(negedge clk);
    wrReg(2'd2, 8'hC3);
    waitIdle();
    chk(monByte == 8'h3C, "R6 shifter untouched by collision", monByte, 8'h3C);
    rdReg(2'd1, v); chk(v == 8'h03, "R6 collision and done", v, 8'h03);
    rdReg(2'd2, v); chk(v == 8'h3C, "R6 received first byte", v, 8'h3C);
    rdReg(2'd1, v); chk(v == 8'h00, "R8 cleared after collision", v, 0);

    // R7 overrun: two bytes without clearing
    wrReg(2'd2, 8'h11);
    waitIdle();
    wrReg(2'd2, 8'h22);
    waitIdle();
    rdReg(2'd1, v); chk(v == 8'h05, "R7 overrun and done", v, 8'h05);
    rdReg(2'd2, v); chk(v == 8'h11, "R7 buffer keeps first byte", v, 8'h11);
    rdReg(2'd1, v); chk(v == 8'h00, "R8 cleared after overrun", v, 0);

    // R8 clearing access lands on the completing edge (H = 2)
    wrReg(2'd2, 8'h6E);
    waitIdle();
    @(negedge clk);
    regAddr = 2'd2; regWdata = 8'h91; regWr = 1'b1;
    for (int k = 1; k <= 33; k++) begin
      @(negedge clk);
      if (k == 1) regWr = 1'b0;
      if (k == 3) begin regAddr = 2'd1; regRd = 1'b1; end
      if (k == 4) regRd = 1'b0;
      if (k == 32) begin
        regAddr = 2'd2; regRd = 1'b1;
        #1 chk(regRdata == 8'h6E, "R8 read during completion", regRdata, 8'h6E);
      end
      if (k == 33) regRd = 1'b0;
    end
    waitIdle();
    rdReg(2'd1, v); chk(v == 8'h05, "R8 done survives same-cycle clear", v, 8'h05);
    rdReg(2'd2, v); chk(v == 8'h6E, "R7 buffer not overwritten", v, 8'h6E);
    rdReg(2'd1, v); chk(v == 8'h00, "R8 cleared afterwards", v, 0);

    // R9 mode fault
    wrReg(2'd0, cfgWord(2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk(masterOe == 1'b1, "R9 master drivers on", masterOe, 1);
    @(negedge clk);
    ssInN = 1'b0;
    repeat (5) @(negedge clk);
    ssInN = 1'b1;
    rdReg(2'd1, v); chk(v == 8'h08, "R9 mode fault flag", v, 8'h08);
    rdReg(2'd0, v); chk(v == 8'h00, "R9 demoted to disabled slave", v, 8'h00);
    chk(masterOe == 1'b0, "R9 master drivers off", masterOe, 0);
    rdReg(2'd2, v);
    rdReg(2'd1, v); chk(v == 8'h00, "R8 mode fault cleared", v, 0);

    // R11 slave collision
    sckIn = 1'b0;
    wrReg(2'd0, cfgWord(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    ssInN = 1'b0;
    repeat (4) @(negedge clk);
    wrReg(2'd2, 8'h77);
    ssInN = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(2'd1, v); chk(v == 8'h02, "R11 slave write collision", v, 8'h02);
    clearFlags();

    // random master transfers (R3 R4 R5)
    for (int n = 0; n < 40; n++)
      masterXfer(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));

    // random slave transfers (R10)
    for (int n = 0; n < 20; n++)
      slaveXfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                8'($urandom_range(0, 255)));

    summary();
  end
endmodule